// File: doc/BRIEF.md
# Indirect matrix-converter switch synthesizer

This block produces the nine gate commands of a three-input, three-output direct AC/AC converter. It treats the converter as a virtual rectifier feeding a virtual inverter. The rectifier stage uses a 12-sector source-angle index to pick which input phase drives each virtual rail. In every legal sector it selects the largest of the three positive line-to-line voltages.

The inverter stage has one hysteresis comparator per output phase. Each comparator looks at that phase's signed current error (reference minus measured) and chooses the upper or lower leg switch. The comparator keeps its previous choice while the error lies within a programmable band.

The two stages are merged by a sum-of-products switching function. An output is joined to an input when its upper leg is chosen and that input holds the positive rail, or when its lower leg is chosen and that input holds the negative rail. All inputs are captured on a sample strobe, which is issued once per control interval. Reset and illegal sector codes turn every switch off.

Top module: `mcs_switch_synth`

## Requirements
- R1: While reset is asserted, and after it until the first sample strobe, all nine gate outputs are 0.
- R2: The sector, the errors and the band are captured only on a clock edge where `sample` is 1. The gates take their new value directly after that edge. On all other edges the gates keep their value, whatever the inputs do.
- R3: A captured sector code of 0, 13, 14 or 15 drives all nine gates to 0.
- R4: The positive rail is driven by input A in sectors 3 to 6, by input B in sectors 7 to 10, and by input C in sectors 11, 12, 1 and 2.
- R5: The negative rail is driven by input B in sectors 1 to 4, by input C in sectors 5 to 8, and by input A in sectors 9 to 12.
- R6: For each output phase, an error strictly greater than `hyst_band` selects the upper leg. An error strictly less than minus `hyst_band` selects the lower leg.
- R7: An error whose magnitude is at most `hyst_band`, including exactly ±band, keeps the leg choice of the previous sample. The leg choice after reset is lower.
- R8: Gate bit 3*x+y (x: output a=0, b=1, c=2; y: input A=0, B=1, C=2) is 1 exactly when output x has upper selected and input y holds the positive rail, or output x has lower selected and input y holds the negative rail. In a legal sector each output phase therefore has exactly one of its three gates set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample | input | 1 | Control-interval strobe; captures the inputs |
| sector | input | 4 | Source-angle sector index, legal values 1 to 12 |
| err_a | input | ERR_W | Signed current error of output phase a |
| err_b | input | ERR_W | Signed current error of output phase b |
| err_c | input | ERR_W | Signed current error of output phase c |
| hyst_band | input | ERR_W-1 | Unsigned hysteresis half-band |
| gate | output | 9 | Switch commands, bit 3*x+y joins output x to input y |

## Verification
The bench probes errors at exactly plus and minus the band, and one step beyond each. A comparator that used non-strict comparisons, or dropped its held state, would flip its leg at the band edge instead of holding.

All twelve sectors are swept with every phase forced upper and then lower. A rail table that was wrong by one sector would connect an output to the wrong input at that sector boundary.

Illegal codes 0 and 13 to 15 are applied between legal ones. A decoder that passed them through would leave gates set.

Long stretches without a strobe, with the inputs changing, expose any path that bypasses the capture register.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int N_PHASE = 3;
    localparam int N_SW    = N_PHASE * N_PHASE;
    localparam int SEC_W   = 4;
    localparam int SEC_MAX = 12;

    typedef struct packed {
        logic [SEC_W-1:0]   sector;
        logic [N_PHASE-1:0] upper;
    } mcs_state_t;
endpackage

// File: rtl/mcs_rectifier.sv
module mcs_rectifier
    import mcs_pkg::*;
(
    input  logic [SEC_W-1:0]   sector,
    output logic               legal,
    output logic [N_PHASE-1:0] pos_sel,
    output logic [N_PHASE-1:0] neg_sel
);
    always_comb begin
        legal   = (sector >= SEC_W'(1)) && (sector <= SEC_W'(SEC_MAX));
        pos_sel = '0;
        neg_sel = '0;
        if (legal) begin
            case (sector)
                4'd3, 4'd4, 4'd5, 4'd6:   pos_sel = 3'b001;
                4'd7, 4'd8, 4'd9, 4'd10:  pos_sel = 3'b010;
                default:                  pos_sel = 3'b100;
            endcase
            case (sector)
                4'd1, 4'd2, 4'd3, 4'd4:   neg_sel = 3'b010;
                4'd5, 4'd6, 4'd7, 4'd8:   neg_sel = 3'b100;
                default:                  neg_sel = 3'b001;
            endcase
        end
    end
endmodule

// File: rtl/mcs_hyst.sv
module mcs_hyst #(
    parameter int ERR_W = 12
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic        [ERR_W-2:0] band,
    input  logic                    prev_up,
    output logic                    next_up
);
    localparam int EXT_W = ERR_W + 1;
    logic signed [EXT_W-1:0] err_x;
    logic signed [EXT_W-1:0] band_x;

    always_comb begin
        err_x  = EXT_W'(err);
        band_x = $signed({2'b00, band});
        if (err_x > band_x)
            next_up = 1'b1;
        else if (err_x < -band_x)
            next_up = 1'b0;
        else
            next_up = prev_up;
    end
endmodule

// File: rtl/mcs_combine.sv
module mcs_combine
    import mcs_pkg::*;
(
    input  logic               legal,
    input  logic [N_PHASE-1:0] upper,
    input  logic [N_PHASE-1:0] pos_sel,
    input  logic [N_PHASE-1:0] neg_sel,
    output logic [N_SW-1:0]    gate
);
    for (genvar x = 0; x < N_PHASE; x++) begin : g_out
        for (genvar y = 0; y < N_PHASE; y++) begin : g_in
            assign gate[x*N_PHASE+y] = legal &
                ((upper[x] & pos_sel[y]) | (~upper[x] & neg_sel[y]));
        end
    end
endmodule

// File: rtl/mcs_switch_synth.sv
module mcs_switch_synth
    import mcs_pkg::*;
#(
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample,
    input  logic [SEC_W-1:0]        sector,
    input  logic signed [ERR_W-1:0] err_a,
    input  logic signed [ERR_W-1:0] err_b,
    input  logic signed [ERR_W-1:0] err_c,
    input  logic        [ERR_W-2:0] hyst_band,
    output logic [N_SW-1:0]         gate
);
    mcs_state_t state_d, state_q;
    logic [N_PHASE-1:0] next_up;
    logic [N_PHASE-1:0] pos_sel, neg_sel;
    logic               legal;
    logic signed [ERR_W-1:0] err_v [N_PHASE];

    assign err_v[0] = err_a;
    assign err_v[1] = err_b;
    assign err_v[2] = err_c;

    for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
        mcs_hyst #(.ERR_W(ERR_W)) u_hyst (
            .err     (err_v[p]),
            .band    (hyst_band),
            .prev_up (state_q.upper[p]),
            .next_up (next_up[p])
        );
    end

    always_comb begin
        state_d = state_q;
        if (sample) begin
            state_d.sector = sector;
            state_d.upper  = next_up;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    mcs_rectifier u_rect (
        .sector  (state_q.sector),
        .legal   (legal),
        .pos_sel (pos_sel),
        .neg_sel (neg_sel)
    );

    mcs_combine u_comb (
        .legal   (legal),
        .upper   (state_q.upper),
        .pos_sel (pos_sel),
        .neg_sel (neg_sel),
        .gate    (gate)
    );
endmodule

// File: rtl/mcs_switch_checker.sv
module mcs_switch_checker #(
    parameter int ERR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample,
    input logic [3:0]              sector,
    input logic signed [ERR_W-1:0] err_a,
    input logic signed [ERR_W-1:0] err_b,
    input logic signed [ERR_W-1:0] err_c,
    input logic        [ERR_W-2:0] hyst_band,
    input logic [8:0]              gate
);
    logic signed [ERR_W:0] bnd;
    logic signed [ERR_W:0] ea, eb, ec;
    logic                  bad_sec;
    assign bnd     = $signed({2'b00, hyst_band});
    assign ea      = (ERR_W+1)'(err_a);
    assign eb      = (ERR_W+1)'(err_b);
    assign ec      = (ERR_W+1)'(err_c);
    assign bad_sec = (sector == 4'd0) || (sector > 4'd12);

    p_reset_off_r1: assert property (@(posedge clk) !rst_n |=> gate == 9'd0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(gate));

    p_illegal_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && bad_sec) |=> gate == 9'd0);

    p_pos_rail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && sector == 4'd9 && ec > bnd) |=> gate[8:6] == 3'b010);

    p_neg_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && sector == 4'd5 && eb < -bnd) |=> gate[5:3] == 3'b100);

    p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && sector == 4'd1 && ea > bnd) |=> gate[2:0] == 3'b100);

    p_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && sector == 4'd1 && ea < -bnd) |=> gate[2:0] == 3'b010);

    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate[2:0]) && $onehot0(gate[5:3]) && $onehot0(gate[8:6]));
endmodule

bind mcs_switch_synth mcs_switch_checker #(.ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample(sample), .sector(sector),
    .err_a(err_a), .err_b(err_b), .err_c(err_c),
    .hyst_band(hyst_band), .gate(gate)
);

// File: tb/tb_mcs_switch_synth.sv
module tb_mcs_switch_synth;
    localparam int ERR_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample = 1'b0;
    logic [3:0] sector = 4'd0;
    logic signed [ERR_W-1:0] err_a = '0, err_b = '0, err_c = '0;
    logic [ERR_W-2:0] hyst_band = 11'd20;
    logic [8:0] gate;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    string cur_req = "R1";

    int m_sector = 0;
    int m_up [3] = '{0, 0, 0};

    always #5 clk = ~clk;

    mcs_switch_synth #(.ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .sample(sample), .sector(sector),
        .err_a(err_a), .err_b(err_b), .err_c(err_c),
        .hyst_band(hyst_band), .gate(gate)
    );

    function automatic int next_leg(int e, int b, int prev);
        if (e > b) return 1;
        if (e < -b) return 0;
        return prev;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sector = 0;
            m_up = '{0, 0, 0};
        end else if (sample) begin
            m_sector = int'(sector);
            m_up[0] = next_leg(int'(err_a), int'(hyst_band), m_up[0]);
            m_up[1] = next_leg(int'(err_b), int'(hyst_band), m_up[1]);
            m_up[2] = next_leg(int'(err_c), int'(hyst_band), m_up[2]);
        end
    end

    function automatic logic [8:0] expect_gate();
        logic [8:0] g = '0;
        int pos, neg;
        if (m_sector < 1 || m_sector > 12) return g;
        if (m_sector >= 3 && m_sector <= 6) pos = 0;
        else if (m_sector >= 7 && m_sector <= 10) pos = 1;
        else pos = 2;
        if (m_sector <= 4) neg = 1;
        else if (m_sector <= 8) neg = 2;
        else neg = 0;
        for (int x = 0; x < 3; x++)
            g[3*x + (m_up[x] != 0 ? pos : neg)] = 1'b1;
        return g;
    endfunction

    always @(negedge clk) begin
        logic [8:0] ex;
        ex = expect_gate();
        n_tests++;
        if (gate !== ex) begin
            n_fail++;
            $display("FAIL %s: gate=%b expected=%b (sector %0d)", cur_req, gate, ex, m_sector);
        end
    end

    task automatic step(input logic s, input int sec, input int ea, input int eb, input int ec);
        @(negedge clk);
        #1;
        sample = s;
        sector = 4'(sec);
        err_a = ERR_W'(ea);
        err_b = ERR_W'(eb);
        err_c = ERR_W'(ec);
    endtask

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) step(1'b0, 5, 500, 500, 500);

        cur_req = "R4";
        for (int s = 1; s <= 12; s++) step(1'b1, s, 300, 300, 300);
        cur_req = "R5";
        for (int s = 1; s <= 12; s++) step(1'b1, s, -300, -300, -300);

        cur_req = "R6";
        for (int s = 1; s <= 12; s++) step(1'b1, s, 21, -21, (s % 2 == 0) ? 2047 : -2048);

        cur_req = "R7";
        step(1'b1, 2, 100, -100, 100);
        step(1'b1, 2, 20, -20, 0);
        step(1'b1, 7, -20, 20, -20);
        step(1'b1, 11, -21, 21, -5);
        step(1'b1, 11, 20, -20, 5);
        hyst_band = 11'd0;
        step(1'b1, 4, 1, -1, 0);
        step(1'b1, 8, 0, 0, 0);
        hyst_band = 11'd2047;
        step(1'b1, 9, 2047, -2047, -2048);
        hyst_band = 11'd20;

        cur_req = "R3";
        step(1'b1, 6, 50, 50, 50);
        step(1'b1, 0, 50, 50, 50);
        step(1'b1, 3, 50, -50, 50);
        step(1'b1, 13, 50, 50, 50);
        step(1'b1, 14, -50, 50, 50);
        step(1'b1, 15, 50, 50, -50);
        step(1'b1, 12, 50, 50, 50);

        cur_req = "R2";
        for (int i = 0; i < 40; i++)
            step(1'b0, $urandom_range(0, 15), $urandom_range(0, 4095) - 2048,
                 $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048);

        cur_req = "R8";
        for (int i = 0; i < 2000; i++) begin
            if (i % 200 == 0) hyst_band = 11'($urandom_range(0, 200));
            step(($urandom_range(0, 3) != 0), $urandom_range(0, 15),
                 $urandom_range(0, 800) - 400, $urandom_range(0, 800) - 400,
                 $urandom_range(0, 800) - 400);
        end

        cur_req = "R1";
        @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (3) step(1'b1, 4, 500, 500, 500);
        @(negedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule